// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Scheduler

This block brings an asynchronous EDO DRAM array out of power-up and then keeps its contents alive. Once reset is released, it stays quiet for a fixed pause given in nanoseconds. It then runs a set number of CAS-before-RAS dummy cycles back to back, with no arbitration, and only after that does it raise its ready flag. From then on a down-counter raises one refresh request per interval. The interval is the retention period divided by the number of rows, so every row is refreshed in time. The memory supplies the row address itself during these cycles, so the block keeps no row counter.

Refresh requests go to the access arbiter over a request/grant handshake. Requests that have not been granted pile up in a small pending counter. When that counter reaches its limit, an urgent flag tells the arbiter to put refresh first. Every granted or initialization cycle drives the two strobes in a fixed order: CAS falls first, then RAS falls and stays low for its minimum width, then both rise together and stay high for at least the precharge time. All times are parameters in nanoseconds and are turned into clock counts. Access requests from the rest of the controller are passed through only once the memory is ready.

Top module: `dram_rfsh_sched`

## Requirements
- R1: During reset, and for at least ceil(PAUSE_NS/CLK_PERIOD_NS) cycles after the internal reset is released, both strobes stay high (1 = inactive) and mem_ready_o stays 0. The first CAS fall comes exactly one cycle after the pause ends.
- R2: After the pause, exactly INIT_CYCLES strobe cycles run back to back, each one starting one idle cycle after the previous one ends. mem_ready_o rises in the cycle after the last one completes and then stays 1.
- R3: In each strobe cycle, CAS falls ceil(T_CSR_NS/CLK_PERIOD_NS) cycles before RAS. RAS stays low for ceil(T_RAS_NS/CLK_PERIOD_NS) cycles. Both rise in the same cycle. RAS stays high for at least ceil(T_RP_NS/CLK_PERIOD_NS) cycles before the next CAS fall.
- R4: The first refresh request is counted INTERVAL cycles after mem_ready_o rises, and after that one every INTERVAL cycles, whatever the grants do. INTERVAL = RETENTION_NS/(ROWS*CLK_PERIOD_NS), rounded down.
- R5: A request that has not been granted stays pending. ref_req_o stays high while at least one is pending and no strobe cycle is running. Each grant sampled while ref_req_o is high starts one strobe cycle, with CAS falling in the next cycle, and removes one pending request.
- R6: The pending count saturates at MAX_POSTPONE. ref_urgent_o is 1 exactly when the count equals MAX_POSTPONE.
- R7: A grant while ref_req_o is 0, including any grant before ready, starts no strobe cycle.
- R8: acc_ok_o is 0 while mem_ready_o is 0, whatever acc_req_i does. Once ready, it follows acc_req_i in the same cycle.
- R9: ref_req_o is 0 while either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_req_i | input | 1 | Access request from the controller |
| acc_ok_o | output | 1 | Access request passed on (only when ready) |
| ref_req_o | output | 1 | Refresh request to the arbiter |
| ref_urgent_o | output | 1 | Pending refreshes at limit; refresh must win |
| ref_gnt_i | input | 1 | Refresh grant from the arbiter |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| mem_ready_o | output | 1 | Initialization finished |

## Verification
The reset synchronizer adds two cycles, so the bench counts every rising edge after it releases reset. From that count it computes the cycle of the first CAS fall (sync + pause + 1), the cycle in which ready rises (sync + pause + INIT_CYCLES × (strobe length + 1)) and each refresh tick (ready cycle + k × INTERVAL). It checks the cycle before and the cycle of each event. A grant is due to show as a CAS fall one edge later, and a pending request comes back on ref_req_o one cycle after the strobe cycle ends. All outputs are sampled on the falling edge, and strobe widths are measured as differences between the edge counts of their transitions.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_t;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_CAS,
    SQ_RAS,
    SQ_PRE
  } seq_st_t;

  // Round a time up to whole clock cycles, never below one cycle.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
    int unsigned c;
    c = (ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

endpackage

// File: rtl/dram_cbr_seq.sv
module dram_cbr_seq
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CAS_CYC = 1,
  parameter int unsigned RAS_CYC = 6,
  parameter int unsigned PRE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);

  localparam int unsigned MAX_A = (CAS_CYC > RAS_CYC) ? CAS_CYC : RAS_CYC;
  localparam int unsigned MAXC  = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
  localparam int unsigned CW    = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] CAS_LD = CW'(CAS_CYC - 1);
  localparam logic [CW-1:0] RAS_LD = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] PRE_LD = CW'(PRE_CYC - 1);

  seq_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;
  logic          seq_en;
  logic          ras_n_q, cas_n_q;

  assign cnt_zero = (cnt_q == '0);
  assign seq_en   = (st_q != SQ_IDLE) || start_i;
  assign busy_o   = (st_q != SQ_IDLE);
  assign ras_n_o  = ras_n_q;
  assign cas_n_o  = cas_n_q;

  // Next-state: CAS lead, RAS pulse, precharge, each a counted phase.
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_o = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (start_i) begin
          st_d  = SQ_CAS;
          cnt_d = CAS_LD;
        end
      end
      SQ_CAS: begin
        if (cnt_zero) begin
          st_d  = SQ_RAS;
          cnt_d = RAS_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_RAS: begin
        if (cnt_zero) begin
          st_d  = SQ_PRE;
          cnt_d = PRE_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_PRE: begin
        if (cnt_zero) begin
          st_d   = SQ_IDLE;
          done_o = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  // Strobes are registered from the next-state decode so they toggle
  // cleanly with the state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else if (seq_en) begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ras_n_q <= (st_d != SQ_RAS);
      cas_n_q <= !((st_d == SQ_CAS) || (st_d == SQ_RAS));
    end
  end

  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n_q |-> !cas_n_q); // R3
  AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n_q) |-> $rose(cas_n_q)); // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o); // R9

endmodule

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
  parameter int unsigned INTERVAL = 1562,
  parameter int unsigned MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic take_i,
  output logic has_pend_o,
  output logic urgent_o
);

  localparam int unsigned TW = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);
  localparam int unsigned QW = $clog2(MAX_PEND + 1);
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);
  localparam logic [QW-1:0] PEND_MAX = QW'(MAX_PEND);

  logic [TW-1:0] tmr_q, tmr_d;
  logic [QW-1:0] pend_q, pend_d;
  logic          tick;
  logic          tmr_en, pend_en;

  assign tick       = en_i && (tmr_q == '0);
  assign tmr_en     = en_i || (tmr_q != RELOAD);
  assign pend_en    = tick || take_i;
  assign has_pend_o = (pend_q != '0);
  assign urgent_o   = (pend_q == PEND_MAX);

  always_comb begin
    tmr_d = (!en_i || tick) ? RELOAD : (tmr_q - 1'b1);
  end

  always_comb begin
    pend_d = pend_q;
    unique case ({tick, take_i})
      2'b10:   pend_d = (pend_q == PEND_MAX) ? pend_q : (pend_q + 1'b1);
      2'b01:   pend_d = pend_q - 1'b1;
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= RELOAD;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_MAX); // R6
  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> (pend_q != '0)); // R5
  AST_NOTHING_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (pend_q == '0)); // R4

endmodule

// File: rtl/dram_init_ctrl.sv
module dram_init_ctrl
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned INIT_CNT  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_busy_i,
  input  logic seq_done_i,
  output logic start_o,
  output logic ready_o
);

  localparam int unsigned PW = (PAUSE_CYC < 2) ? 1 : $clog2(PAUSE_CYC);
  localparam int unsigned IW = $clog2(INIT_CNT + 1);
  localparam logic [PW-1:0] PAUSE_LD = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] INIT_ALL = IW'(INIT_CNT);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_CNT - 1);

  phase_t        phase_q, phase_d;
  logic [PW-1:0] pause_q, pause_d;
  logic [IW-1:0] issued_q, issued_d;
  logic [IW-1:0] fin_q, fin_d;
  logic          ctl_en;

  assign start_o = (phase_q == PH_INIT) && !seq_busy_i && (issued_q != INIT_ALL);
  assign ready_o = (phase_q == PH_RUN);
  assign ctl_en  = (phase_q != PH_RUN);

  always_comb begin
    phase_d  = phase_q;
    pause_d  = pause_q;
    issued_d = issued_q;
    fin_d    = fin_q;
    unique case (phase_q)
      PH_PAUSE: begin
        if (pause_q == '0) phase_d = PH_INIT;
        else               pause_d = pause_q - 1'b1;
      end
      PH_INIT: begin
        if (start_o) issued_d = issued_q + 1'b1;
        if (seq_done_i) begin
          fin_d = fin_q + 1'b1;
          if (fin_q == INIT_LAST) phase_d = PH_RUN;
        end
      end
      default: phase_d = phase_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_PAUSE;
      pause_q  <= PAUSE_LD;
      issued_q <= '0;
      fin_q    <= '0;
    end else if (ctl_en) begin
      phase_q  <= phase_d;
      pause_q  <= pause_d;
      issued_q <= issued_d;
      fin_q    <= fin_d;
    end
  end

  AST_QUIET_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAUSE) |-> !seq_busy_i); // R1
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o); // R2
  AST_READY_AFTER_ALL_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> (fin_q == INIT_ALL)); // R2

endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import dram_rfsh_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned PAUSE_NS      = 200000,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned ROWS          = 4096,
  parameter int unsigned RETENTION_NS  = 64000000,
  parameter int unsigned T_CSR_NS      = 10,
  parameter int unsigned T_RAS_NS      = 60,
  parameter int unsigned T_RP_NS       = 40,
  parameter int unsigned MAX_POSTPONE  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_req_i,
  output logic acc_ok_o,
  output logic ref_req_o,
  output logic ref_urgent_o,
  input  logic ref_gnt_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic mem_ready_o
);

  localparam int unsigned RST_STAGES   = 2;
  localparam int unsigned PAUSE_CYC    = ns_to_cyc(PAUSE_NS, CLK_PERIOD_NS);
  localparam int unsigned INTERVAL_CYC = RETENTION_NS / (ROWS * CLK_PERIOD_NS);
  localparam int unsigned CAS_CYC      = ns_to_cyc(T_CSR_NS, CLK_PERIOD_NS);
  localparam int unsigned RAS_CYC      = ns_to_cyc(T_RAS_NS, CLK_PERIOD_NS);
  localparam int unsigned PRE_CYC      = ns_to_cyc(T_RP_NS, CLK_PERIOD_NS);

  logic [RST_STAGES-1:0] rst_pipe;
  logic rst_int_n;
  logic seq_busy, seq_done, seq_start;
  logic init_start;
  logic has_pend, take;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[RST_STAGES-1];

  assign ref_req_o = mem_ready_o && has_pend && !seq_busy;
  assign take      = ref_req_o && ref_gnt_i;
  assign seq_start = init_start || take;
  assign acc_ok_o  = acc_req_i && mem_ready_o;

  dram_init_ctrl #(
    .PAUSE_CYC (PAUSE_CYC),
    .INIT_CNT  (INIT_CYCLES)
  ) u_init (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .seq_busy_i (seq_busy),
    .seq_done_i (seq_done),
    .start_o    (init_start),
    .ready_o    (mem_ready_o)
  );

  dram_rfsh_timer #(
    .INTERVAL (INTERVAL_CYC),
    .MAX_PEND (MAX_POSTPONE)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_i       (mem_ready_o),
    .take_i     (take),
    .has_pend_o (has_pend),
    .urgent_o   (ref_urgent_o)
  );

  dram_cbr_seq #(
    .CAS_CYC (CAS_CYC),
    .RAS_CYC (RAS_CYC),
    .PRE_CYC (PRE_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (seq_start),
    .busy_o  (seq_busy),
    .done_o  (seq_done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  AST_NO_INIT_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_ready_o |-> !init_start); // R7
  AST_REQ_QUIET_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ras_n_o || !cas_n_o) |-> !ref_req_o); // R9

endmodule

// File: tb/tb_dram_rfsh_sched.sv
module tb_dram_rfsh_sched;

  localparam int CLK_NS = 10;
  localparam int PAUSE_NS = 1000;
  localparam int ROWS = 8;
  localparam int RET_NS = 4000;
  localparam int CSR_NS = 20;
  localparam int RAS_NS = 40;
  localparam int RP_NS = 25;
  localparam int NINIT = 8;
  localparam int MAXP = 3;

  localparam int SYNC = 2;
  localparam int P = (PAUSE_NS + CLK_NS - 1) / CLK_NS;
  localparam int INT = RET_NS / (ROWS * CLK_NS);
  localparam int CAS_C = (CSR_NS + CLK_NS - 1) / CLK_NS;
  localparam int RAS_C = (RAS_NS + CLK_NS - 1) / CLK_NS;
  localparam int PRE_C = (RP_NS + CLK_NS - 1) / CLK_NS;
  localparam int LEN = CAS_C + RAS_C + PRE_C;
  localparam int FIRST_CAS = SYNC + P + 1;
  localparam int E = SYNC + P + NINIT * (LEN + 1);

  logic clk, rst_n, acc_req, acc_ok, ref_req, ref_urg, ref_gnt, ras_n, cas_n, ready;

  int tests, fails, cyc, wd;
  int t_cf, t_rf, t_rr, n_rf, n_rf_init, bad_acc, bad_busy;
  bit have_rise, pcas, pras, finished;

  dram_rfsh_sched #(
    .CLK_PERIOD_NS (CLK_NS), .PAUSE_NS (PAUSE_NS), .INIT_CYCLES (NINIT),
    .ROWS (ROWS), .RETENTION_NS (RET_NS), .T_CSR_NS (CSR_NS),
    .T_RAS_NS (RAS_NS), .T_RP_NS (RP_NS), .MAX_POSTPONE (MAXP)
  ) dut (
    .clk (clk), .rst_n (rst_n), .acc_req_i (acc_req), .acc_ok_o (acc_ok),
    .ref_req_o (ref_req), .ref_urgent_o (ref_urg), .ref_gnt_i (ref_gnt),
    .ras_n_o (ras_n), .cas_n_o (cas_n), .mem_ready_o (ready)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    wd <= wd + 1;
    if (wd > 20000 && !finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired: actual %0d expected %0d", wd, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Strobe-shape and gating monitor, sampled on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pcas && !cas_n) begin
        if (have_rise) check(cyc - t_rr >= PRE_C, "R3 precharge before CAS", cyc - t_rr, PRE_C);
        t_cf = cyc;
      end
      if (pras && !ras_n) begin
        check_eq("R3 CAS-to-RAS lead", cyc - t_cf, CAS_C);
        check_eq("R3 CAS low under RAS", int'(cas_n), 0);
        t_rf = cyc;
        n_rf++;
        if (!ready) n_rf_init++;
      end
      if (!pras && ras_n) begin
        check_eq("R3 RAS low width", cyc - t_rf, RAS_C);
        check_eq("R3 CAS rises with RAS", int'(cas_n), 1);
        t_rr = cyc;
        have_rise = 1'b1;
      end
      if (!ready && acc_ok) bad_acc++;
      if (ref_req && (!ras_n || !cas_n)) bad_busy++;
      pcas = cas_n;
      pras = ras_n;
    end
  end

  task automatic drain(input int exp_grants, input string tag);
    int grants;
    grants = 0;
    for (int it = 0; ref_req && it < 10; it++) begin
      repeat (it % 3) @(negedge clk);
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
      check_eq({tag, " CAS one cycle after grant"}, int'(cas_n), 0);
      grants++;
      repeat (LEN + 2) @(negedge clk);
    end
    check_eq({tag, " grants needed to drain"}, grants, exp_grants);
    check_eq({tag, " request low after drain"}, int'(ref_req), 0);
  endtask

  initial begin
    tests = 0; fails = 0; cyc = 0; wd = 0; finished = 1'b0;
    n_rf = 0; n_rf_init = 0; bad_acc = 0; bad_busy = 0;
    have_rise = 1'b0; pcas = 1'b1; pras = 1'b1; t_cf = 0; t_rf = 0; t_rr = 0;
    rst_n = 1'b0; acc_req = 1'b1; ref_gnt = 1'b1;
    repeat (4) @(negedge clk);
    check_eq("R1 ready low in reset", int'(ready), 0);
    check_eq("R1 RAS high in reset", int'(ras_n), 1);
    check_eq("R1 CAS high in reset", int'(cas_n), 1);
    check_eq("R8 access blocked in reset", int'(acc_ok), 0);
    rst_n = 1'b1;

    wait_cyc(FIRST_CAS - 1);
    check_eq("R1 CAS high at end of pause", int'(cas_n), 1);
    wait_cyc(FIRST_CAS);
    check_eq("R1 first CAS fall after pause", int'(cas_n), 0);

    wait_cyc(E - 1);
    check_eq("R2 ready low before last init cycle ends", int'(ready), 0);
    wait_cyc(E);
    check_eq("R2 ready after init cycles", int'(ready), 1);
    check_eq("R2 R7 RAS pulses before ready (grant held high)", n_rf_init, NINIT);
    check_eq("R8 no access passed before ready", bad_acc, 0);
    check_eq("R8 access passed once ready", int'(acc_ok), 1);
    ref_gnt = 1'b0;

    wait_cyc(E + INT - 1);
    check_eq("R4 no request before first interval", int'(ref_req), 0);
    wait_cyc(E + INT);
    check_eq("R4 request after first interval", int'(ref_req), 1);
    check_eq("R6 not urgent at one pending", int'(ref_urg), 0);

    wait_cyc(E + 3 * INT - 1);
    check_eq("R6 not urgent below limit", int'(ref_urg), 0);
    wait_cyc(E + 3 * INT);
    check_eq("R6 urgent at limit", int'(ref_urg), 1);
    check_eq("R5 request held while ungranted", int'(ref_req), 1);
    drain(MAXP, "R5");

    wait_cyc(E + 4 * INT - 1);
    check_eq("R4 timer independent of grants (before)", int'(ref_req), 0);
    wait_cyc(E + 4 * INT);
    check_eq("R4 timer independent of grants (tick)", int'(ref_req), 1);
    drain(1, "R5 single");

    // Stray grant while nothing is requested.
    ref_gnt = 1'b1;
    @(negedge clk);
    check_eq("R7 stray grant starts no CAS", int'(cas_n), 1);
    @(negedge clk);
    ref_gnt = 1'b0;
    check_eq("R7 stray grant starts no RAS", int'(ras_n), 1);

    acc_req = 1'b0;
    #1;
    check_eq("R8 access follows request low", int'(acc_ok), 0);
    acc_req = 1'b1;
    #1;
    check_eq("R8 access follows request high", int'(acc_ok), 1);

    wait_cyc(E + 9 * INT);
    check_eq("R6 urgent after overflow intervals", int'(ref_urg), 1);
    drain(MAXP, "R6 saturated");
    check_eq("R6 urgent cleared after drain", int'(ref_urg), 0);

    wait_cyc(E + 10 * INT);
    check_eq("R4 periodic request continues", int'(ref_req), 1);
    check_eq("R9 request never high during a strobe cycle", bad_busy, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule